// File: doc/BRIEF.md
# Transposable Flit Buffer

This block is a flip-flop buffer for one group of flits on a parity-protected on-chip link. Each flit is a data word plus one parity bit. The buffer holds the data flits of a group together with the group's parity flit, so it has one more entry than the group has data flits. Flits enter and leave in order, as in any FIFO.

The stored group can also be reached in two other ways. A column is one whole flit, chosen by its position in the queue. A row is one bit position taken across every stored flit, chosen by bit index. A receiver uses row access for repair: when the column parity shows that some bit positions hold errors, it gives the buffer a vector of those bit positions. The buffer then collects one retransmitted row slice for each of them and writes each slice back in place.

A small state machine runs the row rewrite. It has three states:
- `RW_IDLE`: no rewrite is in progress.
- `RW_SEEK`: picks the lowest bit index still pending.
- `RW_AWAIT`: holds that index until its slice arrives.

It has four transitions:
- `RW_IDLE`→`RW_SEEK` on a start pulse.
- `RW_SEEK`→`RW_AWAIT` when an index is still pending.
- `RW_SEEK`→`RW_IDLE` when the pending vector is empty.
- `RW_AWAIT`→`RW_SEEK` when the slice is written.

Top module: `transposable_flit_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `row_busy`=0 and `row_need_valid`=0.
- R2: Flits leave in the order they were accepted. `pop_data` always shows the oldest stored flit, and a `pop_req` that is accepted removes that flit at the clock edge.
- R3: Full and empty come from read/write pointer comparison, with `full` set once DEPTH = GROUP_FLITS+1 flits are stored. A push while full is not accepted (`push_ready`=0), and a pop while empty is ignored.
- R4: `col_rdata` is the flit at queue position `col_idx`, where position 0 is the oldest. It reads zero when `col_idx` is not below the number of stored flits.
- R5: `col_we` overwrites the flit at queue position `col_idx` with `col_wdata` at the clock edge. It is ignored when that position is not occupied.
- R6: `row_rdata` bit j is bit `row_rd_idx` of the flit at queue position j, for j from 0 to DEPTH-1. With a full group, bits 0..GROUP_FLITS-1 are therefore the data flits and bit GROUP_FLITS is the parity flit. A bit reads zero when position j is unoccupied or `row_rd_idx` ≥ DATA_W+1.
- R7: A `row_start` pulse in `RW_IDLE` latches `row_req_vec`. The buffer then serves the set indices one at a time, lowest first. For each index it raises `row_need_valid` with that index on `row_need_idx` and holds it until `row_wvalid`. On `row_wvalid`, bit j of `row_wdata` is written into bit `row_need_idx` of the flit at every occupied queue position j.
- R8: A row write has priority. In a cycle where `row_wvalid` is accepted, `push_ready` is 0, and neither a push nor a column write takes effect.
- R9: While `row_busy` is 1 (any state other than `RW_IDLE`), `pop_req` is ignored and the stored flits stay in place.
- R10: `row_start` is ignored while a rewrite is pending. A start with an all-zero vector goes through `RW_SEEK` and returns to `RW_IDLE` after two clock edges.
- R11: Column and row writes never change `full` or `empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Offer a flit for in-order insertion |
| push_data | input | DATA_W+1 | Flit to insert (data plus parity bit) |
| push_ready | output | 1 | Push is accepted this cycle |
| pop_req | input | 1 | Remove the oldest flit |
| pop_data | output | DATA_W+1 | Oldest stored flit |
| empty | output | 1 | No flits stored |
| full | output | 1 | DEPTH flits stored |
| col_idx | input | clog2(DEPTH) | Queue position for column access |
| col_rdata | output | DATA_W+1 | Flit at `col_idx` |
| col_we | input | 1 | Write `col_wdata` at `col_idx` |
| col_wdata | input | DATA_W+1 | Column write data |
| row_rd_idx | input | clog2(DATA_W+1) | Bit index for row read |
| row_rdata | output | DEPTH | Row slice at `row_rd_idx`, bit j = queue position j |
| row_start | input | 1 | Begin a row rewrite for `row_req_vec` |
| row_req_vec | input | DATA_W+1 | Bit indices to be rewritten |
| row_busy | output | 1 | Row rewrite pending |
| row_need_valid | output | 1 | Waiting for the slice of `row_need_idx` |
| row_need_idx | output | clog2(DATA_W+1) | Bit index whose slice is wanted |
| row_wvalid | input | 1 | Retransmitted slice is present |
| row_wdata | input | DEPTH | Retransmitted slice, bit j = queue position j |

## Verification
Most faults in the pointers or the phase bits show up at once on `full`, `empty` or `pop_data`. The bench compares all three against a queue model on every cycle. A bad position-to-entry mapping corrupts `col_rdata` and `row_rdata` within one cycle for any position it touches, and the bench probes these with random positions and bit indices. A fault in the row rewrite sequencer shows as a wrong or late `row_need_idx`. A slice written into the wrong bit shows on the next row read of either the intended bit or the damaged one.

// File: rtl/tff_pkg.sv
package tff_pkg;

    typedef enum logic [1:0] {
        RW_IDLE  = 2'd0,
        RW_SEEK  = 2'd1,
        RW_AWAIT = 2'd2
    } rw_state_e;

endpackage

// File: rtl/tff_ptr_ctrl.sv
module tff_ptr_ctrl #(
    parameter int DEPTH = 5,
    parameter int PTR_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_go,
    input  logic             pop_go,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [PTR_W-1:0] rd_q, wr_q;
    logic             rd_ph_q, wr_ph_q;
    logic             rd_last, wr_last;

    assign rd_last = (rd_q == PTR_W'(DEPTH - 1));
    assign wr_last = (wr_q == PTR_W'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= '0;
            wr_q    <= '0;
            rd_ph_q <= 1'b0;
            wr_ph_q <= 1'b0;
        end else begin
            if (push_go) begin
                wr_q    <= wr_last ? '0 : wr_q + 1'b1;
                wr_ph_q <= wr_last ? ~wr_ph_q : wr_ph_q;
            end
            if (pop_go) begin
                rd_q    <= rd_last ? '0 : rd_q + 1'b1;
                rd_ph_q <= rd_last ? ~rd_ph_q : rd_ph_q;
            end
        end
    end

    always_comb begin
        int diff;
        diff = int'(wr_q) - int'(rd_q);
        if (rd_ph_q != wr_ph_q) diff = diff + DEPTH;
        count = CNT_W'(diff);
    end

    assign full   = (rd_q == wr_q) && (rd_ph_q != wr_ph_q);
    assign empty  = (rd_q == wr_q) && (rd_ph_q == wr_ph_q);
    assign rd_ptr = rd_q;
    assign wr_ptr = wr_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |-> !full);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_go |-> !empty);
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

endmodule

// File: rtl/tff_row_fsm.sv
module tff_row_fsm
    import tff_pkg::*;
#(
    parameter int FLIT_W = 9,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FLIT_W-1:0] req_vec,
    input  logic              wvalid,
    output logic              busy,
    output logic              need_valid,
    output logic [IDX_W-1:0]  need_idx,
    output logic              row_wr
);

    rw_state_e         state_q, state_d;
    logic [FLIT_W-1:0] vec_q, vec_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [IDX_W-1:0]  low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = FLIT_W - 1; i >= 0; i--) begin
            if (vec_q[i]) low_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RW_IDLE;
            vec_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        idx_d   = idx_q;
        unique case (state_q)
            RW_IDLE: begin
                if (start) begin
                    state_d = RW_SEEK;
                    vec_d   = req_vec;
                end
            end
            RW_SEEK: begin
                if (vec_q == '0) begin
                    state_d = RW_IDLE;
                end else begin
                    state_d = RW_AWAIT;
                    idx_d   = low_idx;
                    vec_d   = vec_q & ~(FLIT_W'(1) << low_idx);
                end
            end
            RW_AWAIT: begin
                if (wvalid) state_d = RW_SEEK;
            end
            default: state_d = RW_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b1;
        need_valid = 1'b0;
        unique case (state_q)
            RW_IDLE:  busy = 1'b0;
            RW_SEEK:  need_valid = 1'b0;
            RW_AWAIT: need_valid = 1'b1;
            default:  busy = 1'b0;
        endcase
        need_idx = idx_q;
        row_wr   = need_valid && wvalid;
    end

    // R7
    await_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_valid && !wvalid) |=> (need_valid && $stable(need_idx)));
    // R7
    write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_wr |=> (busy && !need_valid));
    // R10
    seek_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RW_SEEK && vec_q == '0) |=> !busy);
    // R10
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !need_valid));

endmodule

// File: rtl/tff_store.sv
module tff_store #(
    parameter int DEPTH  = 5,
    parameter int FLIT_W = 9,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [CNT_W-1:0]  count,
    input  logic              push_en,
    input  logic [FLIT_W-1:0] push_data,
    input  logic              col_en,
    input  logic [PTR_W-1:0]  col_pos,
    input  logic [FLIT_W-1:0] col_data,
    input  logic              row_en,
    input  logic [IDX_W-1:0]  row_bit,
    input  logic [DEPTH-1:0]  row_slice,
    input  logic [PTR_W-1:0]  col_rpos,
    input  logic [IDX_W-1:0]  row_ridx,
    output logic [FLIT_W-1:0] head_data,
    output logic [FLIT_W-1:0] col_rdata,
    output logic [DEPTH-1:0]  row_rdata
);

    logic [FLIT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  ent_lpos [DEPTH];
    logic              ent_occ  [DEPTH];
    logic [PTR_W-1:0]  pos_phys [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_map
        assign ent_lpos[g] = PTR_W'((g + DEPTH - int'(rd_ptr)) % DEPTH);
        assign ent_occ[g]  = int'(ent_lpos[g]) < int'(count);
        assign pos_phys[g] = PTR_W'((g + int'(rd_ptr)) % DEPTH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (row_en) begin
                    if (ent_occ[e]) mem_q[e][row_bit] <= row_slice[ent_lpos[e]];
                end else begin
                    if (push_en && wr_ptr == PTR_W'(e)) mem_q[e] <= push_data;
                    if (col_en && ent_occ[e] && ent_lpos[e] == col_pos)
                        mem_q[e] <= col_data;
                end
            end
        end
    end

    always_comb begin
        head_data = mem_q[rd_ptr];
        col_rdata = '0;
        if (int'(col_rpos) < int'(count)) col_rdata = mem_q[pos_phys[col_rpos]];
        row_rdata = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (j < int'(count) && int'(row_ridx) < FLIT_W)
                row_rdata[j] = mem_q[pos_phys[j]][row_ridx];
        end
    end

    // R5
    col_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_en |-> int'(col_pos) < int'(count));
    // R3
    push_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> int'(count) < DEPTH);

endmodule

// File: rtl/transposable_flit_fifo.sv
module transposable_flit_fifo #(
    parameter int DATA_W      = 8,
    parameter int GROUP_FLITS = 4,
    localparam int FLIT_W = DATA_W + 1,
    localparam int DEPTH  = GROUP_FLITS + 1,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(FLIT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [FLIT_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop_req,
    output logic [FLIT_W-1:0] pop_data,
    output logic              empty,
    output logic              full,
    input  logic [PTR_W-1:0]  col_idx,
    output logic [FLIT_W-1:0] col_rdata,
    input  logic              col_we,
    input  logic [FLIT_W-1:0] col_wdata,
    input  logic [IDX_W-1:0]  row_rd_idx,
    output logic [DEPTH-1:0]  row_rdata,
    input  logic              row_start,
    input  logic [FLIT_W-1:0] row_req_vec,
    output logic              row_busy,
    output logic              row_need_valid,
    output logic [IDX_W-1:0]  row_need_idx,
    input  logic              row_wvalid,
    input  logic [DEPTH-1:0]  row_wdata
);

    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push_go, pop_go, col_go, row_wr;

    assign push_ready = !full && !row_wr;
    assign push_go    = push_valid && push_ready;
    assign pop_go     = pop_req && !empty && !row_busy;
    assign col_go     = col_we && !row_wr && (int'(col_idx) < int'(count));

    tff_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .push_go(push_go), .pop_go(pop_go),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .count(count),
        .full(full), .empty(empty)
    );

    tff_row_fsm #(.FLIT_W(FLIT_W), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(row_start), .req_vec(row_req_vec),
        .wvalid(row_wvalid), .busy(row_busy), .need_valid(row_need_valid),
        .need_idx(row_need_idx), .row_wr(row_wr)
    );

    tff_store #(.DEPTH(DEPTH), .FLIT_W(FLIT_W), .PTR_W(PTR_W),
                .CNT_W(CNT_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .count(count), .push_en(push_go), .push_data(push_data),
        .col_en(col_go), .col_pos(col_idx), .col_data(col_wdata),
        .row_en(row_wr), .row_bit(row_need_idx), .row_slice(row_wdata),
        .col_rpos(col_idx), .row_ridx(row_rd_idx),
        .head_data(pop_data), .col_rdata(col_rdata), .row_rdata(row_rdata)
    );

    // R8
    row_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_wr |-> (!push_go && !col_go));
    // R9
    pop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_busy |-> !pop_go);
    // R9
    busy_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_busy && !row_wr) |=> $stable(pop_data) || !row_busy);
    // R11
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((col_go || row_wr) && !push_go && !pop_go) |=> ($stable(full) && $stable(empty)));

endmodule

// File: tb/transposable_flit_fifo_tb_top.sv
module transposable_flit_fifo_tb_top;

    localparam int DW = 8;
    localparam int M  = 4;
    localparam int FW = DW + 1;
    localparam int D  = M + 1;

    logic          clk, rst_n;
    logic          push_valid, push_ready, pop_req, empty, full;
    logic [FW-1:0] push_data, pop_data, col_rdata, col_wdata, row_req_vec;
    logic [2:0]    col_idx;
    logic          col_we, row_start, row_busy, row_need_valid, row_wvalid;
    logic [3:0]    row_rd_idx, row_need_idx;
    logic [D-1:0]  row_rdata, row_wdata;

    transposable_flit_fifo #(.DATA_W(DW), .GROUP_FLITS(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .pop_req(pop_req), .pop_data(pop_data),
        .empty(empty), .full(full), .col_idx(col_idx), .col_rdata(col_rdata),
        .col_we(col_we), .col_wdata(col_wdata), .row_rd_idx(row_rd_idx),
        .row_rdata(row_rdata), .row_start(row_start), .row_req_vec(row_req_vec),
        .row_busy(row_busy), .row_need_valid(row_need_valid),
        .row_need_idx(row_need_idx), .row_wvalid(row_wvalid), .row_wdata(row_wdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [FW-1:0] mq [D];
    int            mcnt = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [D-1:0] exp_row(int k);
        logic [D-1:0] r = '0;
        for (int j = 0; j < D; j++)
            if (j < mcnt && k < FW) r[j] = mq[j][k];
        return r;
    endfunction

    function automatic logic [FW-1:0] exp_col(int p);
        return (p < mcnt) ? mq[p] : '0;
    endfunction

    task automatic clear_in();
        push_valid = 0; push_data = '0; pop_req = 0; col_we = 0; col_wdata = '0;
        row_start = 0; row_req_vec = '0; row_wvalid = 0; row_wdata = '0;
    endtask

    task automatic probe(int ci, int ri);
        col_idx = 3'(ci); row_rd_idx = 4'(ri);
        #1;
        chk("R3 empty", 32'(empty), 32'(mcnt == 0));
        chk("R3 full", 32'(full), 32'(mcnt == D));
        if (mcnt > 0) chk("R2 head", 32'(pop_data), 32'(mq[0]));
        chk("R4 col read", 32'(col_rdata), 32'(exp_col(ci)));
        chk("R6 row read", 32'(row_rdata), 32'(exp_row(ri)));
    endtask

    // one idle-FSM cycle with push / pop / column write
    task automatic cycle(bit pv, logic [FW-1:0] pd, bit pp, bit cw, int ci, logic [FW-1:0] cd);
        bit pgo, qgo, cgo;
        push_valid = pv; push_data = pd; pop_req = pp;
        col_we = cw; col_idx = 3'(ci); col_wdata = cd;
        #1;
        chk("R3 push_ready", 32'(push_ready), 32'(mcnt < D));
        pgo = pv && (mcnt < D);
        qgo = pp && (mcnt > 0);
        cgo = cw && (ci < mcnt);
        @(negedge clk);
        if (cgo) mq[ci] = cd;
        if (qgo) begin
            for (int j = 0; j < D - 1; j++) mq[j] = mq[j+1];
            mcnt--;
        end
        if (pgo) begin
            mq[mcnt] = pd;
            mcnt++;
        end
        clear_in();
    endtask

    task automatic do_row(logic [FW-1:0] vec, bit poke);
        logic [D-1:0] sl;
        row_start = 1; row_req_vec = vec;
        @(negedge clk);
        clear_in();
        #1;
        chk("R7 busy after start", 32'(row_busy), 32'd1);
        chk("R7 seek no need", 32'(row_need_valid), 32'd0);
        for (int k = 0; k < FW; k++) begin
            if (vec[k]) begin
                @(negedge clk);
                #1;
                chk("R7 need valid", 32'(row_need_valid), 32'd1);
                chk("R7 need idx", 32'(row_need_idx), 32'(k));
                if (poke) begin
                    pop_req = 1;
                    @(negedge clk);
                    pop_req = 0;
                    #1;
                    chk("R9 pop blocked head", 32'(pop_data), 32'(mq[0]));
                    chk("R9 pop blocked col", 32'(col_rdata), 32'(exp_col(int'(col_idx))));
                    chk("R7 need held", 32'(row_need_idx), 32'(k));
                end
                sl = D'($urandom);
                row_wvalid = 1; row_wdata = sl;
                if (poke) begin
                    push_valid = 1; push_data = 9'h1AA; pop_req = 1;
                    col_we = 1; col_idx = 3'd0; col_wdata = 9'h155;
                    row_start = 1; row_req_vec = '1;
                end
                #1;
                chk("R8 push_ready low on row write", 32'(push_ready), 32'd0);
                @(negedge clk);
                clear_in();
                for (int j = 0; j < mcnt; j++) mq[j][k] = sl[j];
                #1;
                chk("R8 count unchanged", 32'(full), 32'(mcnt == D));
            end
        end
        @(negedge clk);
        #1;
        chk("R10 idle after vector drained", 32'(row_busy), 32'd0);
        for (int k = 0; k < FW; k++) probe(k % D, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_in();
        col_idx = '0; row_rd_idx = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 busy", 32'(row_busy), 32'd0);
        chk("R1 need", 32'(row_need_valid), 32'd0);

        // R2 R3: fill the group, data flits then parity flit
        for (int i = 0; i < D; i++) cycle(1, FW'(9'h101 + 9'h022 * i), 0, 0, 0, '0);
        probe(4, 0);
        cycle(1, 9'h0FF, 0, 0, 0, '0); // R3 push while full
        probe(4, 8);
        for (int p = 0; p < 8; p++) probe(p, p);   // R4 R6 including out of range

        // R5 R11: column writes in and out of occupancy
        cycle(0, '0, 0, 1, 2, 9'h0C3);
        probe(2, 3);
        cycle(0, '0, 1, 0, 0, '0);
        cycle(0, '0, 0, 1, 4, 9'h1E1); // position 4 unoccupied: ignored
        probe(4, 4);
        chk("R11 not full after col write", 32'(full), 32'd0);

        // R7 R8 R9 R10 with poking
        do_row(9'b010000010, 1);
        do_row('0, 0);                 // R10 empty vector
        cycle(1, 9'h033, 0, 0, 0, '0);
        do_row(9'b100000001, 0);
        chk("R11 full kept across row writes", 32'(full), 32'd1);

        // R2 drain in order, then R3 pop on empty
        while (mcnt > 0) begin
            probe(0, 1);
            cycle(0, '0, 1, 0, 0, '0);
        end
        cycle(0, '0, 1, 0, 0, '0);
        probe(0, 0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 12);
            probe(int'($urandom % 8), int'($urandom % 16));
            if (op == 0 && mcnt > 0)
                do_row(FW'($urandom), bit'($urandom % 2));
            else
                cycle(($urandom % 2) == 0, FW'($urandom), ($urandom % 3) == 0,
                      ($urandom % 4) == 0, int'($urandom % 8), FW'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule